// File: doc/BRIEF.md
# Cache Region Refill Tracker

This block keeps one flag for each 32 KB slice of a 1 MB address window. Flush software can then split a long cache flush into short pieces. Each time a cache line fill is reported on the fill port, the flag for the slice that holds the fill address is set. The slice index comes from fill address bits [19:15]. Any address bits above bit 19 are ignored, so every 1 MB bank of a larger cache folds onto the same 32 flags.

Software flushes a group of slices and then clears their flags by writing ones to them. If the flush is interrupted and those slices are refilled, the refills set the flags again. A later read of the register therefore shows which slices still need a second pass. The register sits at one fixed address on a simple CPU read/write port. After reset every flag is set, so every slice counts as possibly holding data until it has been flushed.

Top module: `refill_tracker`

## Requirements
- R1: After reset every one of the 32 flags reads as 1, and `cpuRdata` is 0 until the first read.
- R2: A cycle with `fillValid` high sets the flag whose index is `fillAddr[19:15]`. The new value is visible to a read issued in the next cycle.
- R3: `fillAddr` bits above bit 19 have no effect. Fills that differ only in those bits set the same flag.
- R4: A cycle with `fillValid` low sets no flag, whatever value `fillAddr` holds.
- R5: A write (`cpuValid`=1, `cpuWrite`=1, matching address) clears each flag whose bit in `cpuWdata` is 1. Flags whose bit in `cpuWdata` is 0 keep their value.
- R6: When a fill and a clearing write target the same flag in the same cycle, the flag ends up set.
- R7: A read (`cpuValid`=1, `cpuWrite`=0, matching address) loads the flags as they were before that clock edge into `cpuRdata`, one cycle later. Reads change no flag. `cpuRdata` holds its value in cycles with no read.
- R8: An access whose `cpuAddr` differs from parameter `REG_ADDR` (default 12'h0C0) neither clears a flag nor updates `cpuRdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fillValid | input | 1 | Marks a cache line fill in this cycle |
| fillAddr | input | ADDR_W (40) | Byte address of the fill |
| cpuValid | input | 1 | CPU register access strobe |
| cpuWrite | input | 1 | 1 = write (clear ones), 0 = read |
| cpuAddr | input | CSR_ADDR_W (12) | CPU register address |
| cpuWdata | input | 32 | Write data; a 1 clears the matching flag |
| cpuRdata | output | 32 | Read data, registered |

## Verification
The bench targets the case where a fill and a clear hit the same flag in the same cycle. A design that lets the clear win would lose the refill, and the next read would show 0 for a slice that holds data. It sends fills whose addresses carry high bits and offsets at both edges of a slice. A decoder that took the wrong bit range would mark the wrong slice, or would not fold larger banks onto the window. It also writes zeros, accesses other addresses and issues repeated reads. Any of these steps changing a flag or `cpuRdata` marks a decode or side-effect fault.

// File: rtl/refill_tracker_pkg.sv
package refill_tracker_pkg;
  localparam int SLICES    = 32;
  localparam int SLICE_LSB = 15;
  localparam int IDX_W     = $clog2(SLICES);

  typedef logic [SLICES-1:0] flagVec_t;

  typedef struct packed {
    flagVec_t setMask;
    flagVec_t clrMask;
    logic     rdEn;
  } trackStrb_t;
endpackage

// File: rtl/refill_tracker_ctrl.sv
module refill_tracker_ctrl
  import refill_tracker_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int CSR_ADDR_W = 12,
  parameter logic [CSR_ADDR_W-1:0] REG_ADDR = 12'h0C0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fillValid,
  input  logic [ADDR_W-1:0]     fillAddr,
  input  logic                  cpuValid,
  input  logic                  cpuWrite,
  input  logic [CSR_ADDR_W-1:0] cpuAddr,
  input  logic [SLICES-1:0]     cpuWdata,
  output trackStrb_t            strb
);
  logic [IDX_W-1:0] sliceIdx;
  logic             regHit;

  // Only the offset inside the 1 MB window selects a slice
  assign sliceIdx = fillAddr[SLICE_LSB+IDX_W-1:SLICE_LSB];
  assign regHit   = cpuValid && (cpuAddr == REG_ADDR);

  for (genvar n = 0; n < SLICES; n++) begin : g_dec
    assign strb.setMask[n] = fillValid && (sliceIdx == IDX_W'(n));
    assign strb.clrMask[n] = regHit && cpuWrite && cpuWdata[n];
  end
  assign strb.rdEn = regHit && !cpuWrite;

  // R4
  no_fill_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fillValid |-> (strb.setMask == '0));

  // R2
  one_slice_per_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fillValid |-> ($countones(strb.setMask) == 1));

  // R8
  foreign_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuAddr != REG_ADDR) |-> (strb.clrMask == '0 && !strb.rdEn));
endmodule

// File: rtl/refill_tracker_dp.sv
module refill_tracker_dp
  import refill_tracker_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trackStrb_t strb,
  output flagVec_t   rdData
);
  flagVec_t flagsQ;

  // Set is applied after clear so that a refill is never lost
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flagsQ <= '1;
      rdData <= '0;
    end else begin
      flagsQ <= (flagsQ & ~strb.clrMask) | strb.setMask;
      if (strb.rdEn) rdData <= flagsQ;
    end
  end

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.setMask != '0) |=> ((flagsQ & $past(strb.setMask)) == $past(strb.setMask)));

  // R6
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((strb.setMask & strb.clrMask) != '0) |=>
      ((flagsQ & $past(strb.setMask & strb.clrMask)) == $past(strb.setMask & strb.clrMask)));

  // R5
  no_stray_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flagsQ) & ~flagsQ & ~$past(strb.clrMask)) == '0));

  // R4
  no_stray_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(flagsQ) & flagsQ & ~$past(strb.setMask)) == '0));

  // R7
  read_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdEn |=> (rdData == $past(flagsQ)));

  // R7
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.rdEn |=> $stable(rdData));
endmodule

// File: rtl/refill_tracker.sv
module refill_tracker
  import refill_tracker_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int CSR_ADDR_W = 12,
  parameter logic [CSR_ADDR_W-1:0] REG_ADDR = 12'h0C0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fillValid,
  input  logic [ADDR_W-1:0]     fillAddr,
  input  logic                  cpuValid,
  input  logic                  cpuWrite,
  input  logic [CSR_ADDR_W-1:0] cpuAddr,
  input  logic [31:0]           cpuWdata,
  output logic [31:0]           cpuRdata
);
  trackStrb_t strb;

  refill_tracker_ctrl #(
    .ADDR_W(ADDR_W), .CSR_ADDR_W(CSR_ADDR_W), .REG_ADDR(REG_ADDR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fillValid(fillValid), .fillAddr(fillAddr),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .strb(strb)
  );

  refill_tracker_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .rdData(cpuRdata)
  );
endmodule

// File: tb/refill_tracker_bench.sv
`timescale 1ns/1ps
module refill_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fillValid = 1'b0;
  logic [39:0] fillAddr = '0;
  logic        cpuValid = 1'b0;
  logic        cpuWrite = 1'b0;
  logic [11:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;

  localparam logic [11:0] REG = 12'h0C0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] modelFlags;
  logic [31:0] modelRd;

  always #2.5 clk = ~clk;

  refill_tracker u_refill_tracker (
    .clk(clk), .rst_n(rst_n),
    .fillValid(fillValid), .fillAddr(fillAddr),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata)
  );

  task automatic compare(input string req);
    checks++;
    if (cpuRdata !== modelRd) begin
      failures++;
      $display("FAIL %s: cpuRdata actual=%h expected=%h", req, cpuRdata, modelRd);
    end
  endtask

  // One clock: apply inputs, advance model, check on the next falling edge
  task automatic step(input string req, input bit fv, input logic [39:0] fa,
                      input bit cv, input bit cw, input logic [11:0] ca,
                      input logic [31:0] wd);
    logic [31:0] setM, clrM;
    bit hit;
    fillValid = fv; fillAddr = fa;
    cpuValid = cv; cpuWrite = cw; cpuAddr = ca; cpuWdata = wd;
    @(posedge clk);
    hit  = cv && (ca == REG);
    setM = fv ? (32'h1 << ((fa % 40'h100000) / 40'h8000)) : 32'h0;
    clrM = (hit && cw) ? wd : 32'h0;
    if (hit && !cw) modelRd = modelFlags;
    modelFlags = (modelFlags & ~clrM) | setM;
    @(negedge clk);
    fillValid = 0; cpuValid = 0;
    compare(req);
  endtask

  task automatic rd(input string req);
    step(req, 0, 40'h0, 1, 0, REG, 32'h0);
    step(req, 0, 40'h0, 0, 0, REG, 32'h0);
  endtask

  task automatic clr(input string req, input logic [31:0] m);
    step(req, 0, 40'h0, 1, 1, REG, m);
  endtask

  task automatic fill(input string req, input logic [39:0] a);
    step(req, 1, a, 0, 0, REG, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    modelFlags = 32'hFFFF_FFFF;
    modelRd = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    rd("R1");
    // clear all, confirm empty
    clr("R5", 32'hFFFF_FFFF);
    rd("R5");
    // single fills
    fill("R2", 40'h00_0000_8000);
    rd("R2");
    fill("R2", 40'h00_000F_FFFF);
    rd("R2");
    // aliasing across 1 MB banks
    fill("R3", 40'h01_23F8_1234);
    fill("R3", 40'hFF_FFF0_0000);
    rd("R3");
    // fill port without valid
    step("R4", 0, 40'h00_0005_0000, 0, 0, REG, 32'h0);
    rd("R4");
    // partial and zero clears
    clr("R5", 32'h0000_0002);
    clr("R5", 32'h0000_0000);
    rd("R5");
    // collision: fill slice 5 while clearing slice 5 and others
    step("R6", 1, 40'h00_0002_8100, 1, 1, REG, 32'hFFFF_FFFF);
    rd("R6");
    // fill in the same cycle as a read
    step("R7", 1, 40'h00_0003_0000, 1, 0, REG, 32'h0);
    rd("R7");
    rd("R7");
    // foreign address accesses
    fill("R8", 40'h00_0004_0000);
    step("R8", 0, 40'h0, 1, 1, 12'h0C4, 32'hFFFF_FFFF);
    step("R8", 0, 40'h0, 1, 0, 12'h8C0, 32'h0);
    rd("R8");
    // sweep every slice at its last byte, alternating bank bits
    clr("R5", 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      fill("R2", (40'(n) << 20) | (40'(n) * 40'h8000 + 40'h7FFF));
      rd("R2");
      clr("R5", 32'h1 << n);
    end
    rd("R5");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule